// File: doc/BRIEF.md
# Digital Potentiometer Command Layer

This block sits between a two-wire serial slave front end and a bank of wiper position registers. The front end handles bit timing, addressing and acknowledge. It passes this block one-cycle events in the system clock domain: start, stop, a received byte, and, while the step mode is open, a clock pulse with the sampled data level. The block decodes the first byte after the address into an operation, a pot index and a register index. It then sequences the rest of the transaction: transfers that finish after the command byte, read and write operations that need a third byte, and an open-ended step mode.

Each pot has one volatile wiper register and four data registers. The data registers are held in one memory that can be inferred as block RAM. That memory keeps its contents across reset, which stands in for nonvolatile storage. Changes to a data register are buffered and only written after stop. Each such commit raises a busy flag for a parameterised number of clock cycles. Wiper changes take effect at once and never raise busy. After reset, each wiper is reloaded from its pot's register 0.

Top module: `pot_cmd_regfile`

## Requirements
- R1: After reset, `busy_o` is high in the first cycle and then falls within 8 cycles. By that point each wiper equals register 0 of its own pot, and that register keeps its value across reset.
- R2: In the command byte, bits 7:4 select the operation, bits 3:2 the pot and bits 1:0 the data register. Only the selected pot is affected by a single-pot operation.
- R3: Operation 1010 followed by a data byte loads that byte into the selected wiper at once, without raising `busy_o`.
- R4: Operation 1001 places the selected wiper on `rd_data_o`, and operation 1011 places the selected data register there, both within 3 cycles of the command byte. Any further byte in the same transaction changes nothing.
- R5: Operation 1100 followed by a data byte changes nothing before stop. After stop, the register holds the byte and `busy_o` is high for exactly `NV_CYCLES` cycles starting the cycle after stop.
- R6: A start that arrives before stop discards a buffered register write. The register keeps its old value and `busy_o` stays low.
- R7: Operation 1101 copies the selected data register into the selected wiper, without raising `busy_o`.
- R8: Operation 1110 stores the selected wiper into the selected data register of that pot on stop, with a busy window.
- R9: Operation 0001 loads every wiper from its own pot's register given by bits 1:0.
- R10: Operation 1000 stores every wiper into its own pot's register given by bits 1:0 on stop, with a busy window.
- R11: After operation 0010, each step pulse moves the selected wiper's position (bits 5:0) one step up when the sampled level is 1 and one step down when it is 0. The position saturates at 0 and 63, and bits 7:6 are kept. Step pulses have no effect after stop.
- R12: Unused operation codes, for example 0000 and 1111, change no wiper, no register and no busy state.
- R13: While `busy_o` is high, start, stop, bytes and step pulses are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start (or repeated start) seen and addressed to this block |
| stop_i | input | 1 | Stop condition seen |
| byte_valid_i | input | 1 | One-cycle strobe: a byte was received |
| byte_i | input | 8 | Received byte |
| step_i | input | 1 | One-cycle strobe: a clock high pulse occurred while in step mode |
| step_up_i | input | 1 | Data level sampled with that pulse (1 = up) |
| rd_data_o | output | 8 | Byte offered to the front end for a read's third byte |
| busy_o | output | 1 | Reload after reset or nonvolatile write cycle in progress |
| wcr_o | output | NPOTS*DW | All wiper registers, pot 0 in the low byte |

## Verification
The assertions assume that the front end never pulses two events in the same cycle. They also assume consecutive events are at least six cycles apart, so a transfer sequence of up to five cycles always finishes before the next event. Under that assumption, no wiper load can overlap a busy window, and the read and write engines never compete for the memory. The bench drives every event through tasks that wait eight cycles afterwards, which keeps the stimulus inside that envelope. It deliberately sends events while busy is high to show they are dropped.

// File: rtl/pot_cmd_pkg.sv
package pot_cmd_pkg;

  // operation encodings of the command byte's upper nibble
  localparam logic [3:0] OPC_RD_WCR = 4'b1001;
  localparam logic [3:0] OPC_WR_WCR = 4'b1010;
  localparam logic [3:0] OPC_RD_DR  = 4'b1011;
  localparam logic [3:0] OPC_WR_DR  = 4'b1100;
  localparam logic [3:0] OPC_D2W    = 4'b1101;
  localparam logic [3:0] OPC_W2D    = 4'b1110;
  localparam logic [3:0] OPC_G_D2W  = 4'b0001;
  localparam logic [3:0] OPC_G_W2D  = 4'b1000;
  localparam logic [3:0] OPC_STEP   = 4'b0010;

  typedef enum logic [3:0] {
    K_NONE, K_RD_WCR, K_WR_WCR, K_RD_DR, K_WR_DR,
    K_D2W, K_W2D, K_G_D2W, K_G_W2D, K_STEP
  } kind_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_WDATA, ST_RDATA, ST_STEP, ST_DONE
  } phase_e;

endpackage

// File: rtl/pot_cmd_decode.sv
module pot_cmd_decode
  import pot_cmd_pkg::*;
#(
  parameter int PW = 2,
  parameter int RW = 2
) (
  input  logic [7:0]    cmd_i,
  output kind_e         kind_o,
  output logic [PW-1:0] pot_o,
  output logic [RW-1:0] reg_o
);

  always_comb begin
    unique case (cmd_i[7:4])
      OPC_RD_WCR: kind_o = K_RD_WCR;
      OPC_WR_WCR: kind_o = K_WR_WCR;
      OPC_RD_DR:  kind_o = K_RD_DR;
      OPC_WR_DR:  kind_o = K_WR_DR;
      OPC_D2W:    kind_o = K_D2W;
      OPC_W2D:    kind_o = K_W2D;
      OPC_G_D2W:  kind_o = K_G_D2W;
      OPC_G_W2D:  kind_o = K_G_W2D;
      OPC_STEP:   kind_o = K_STEP;
      default:    kind_o = K_NONE;
    endcase
  end

  assign pot_o = cmd_i[RW+PW-1:RW];
  assign reg_o = cmd_i[RW-1:0];

endmodule

// File: rtl/pot_regfile.sv
module pot_regfile #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);

  logic [DW-1:0] mem [DEPTH];

  // contents survive reset: this array models the nonvolatile cells
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end

endmodule

// File: rtl/pot_wiper.sv
module pot_wiper #(
  parameter int DW    = 8,
  parameter int POS_W = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_i,
  input  logic [DW-1:0] ld_val_i,
  input  logic          step_i,
  input  logic          up_i,
  output logic [DW-1:0] wcr_o
);

  localparam logic [POS_W-1:0] POS_TOP = '1;

  logic [POS_W-1:0] pos;
  assign pos = wcr_o[POS_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      wcr_o <= '0;
    end else if (ld_i) begin
      wcr_o <= ld_val_i;
    end else if (step_i) begin
      if (up_i && pos != POS_TOP)
        wcr_o[POS_W-1:0] <= pos + 1'b1;
      else if (!up_i && pos != '0)
        wcr_o[POS_W-1:0] <= pos - 1'b1;
    end
  end

endmodule

// File: rtl/pot_nv_timer.sv
module pot_nv_timer #(
  parameter int CYCLES = 2_000_000,
  localparam int CW    = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic busy_o
);

  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst)                remain <= '0;
    else if (start_i)       remain <= CW'(CYCLES);
    else if (remain != '0)  remain <= remain - 1'b1;
  end

  assign busy_o = (remain != '0);

endmodule

// File: rtl/pot_cmd_regfile.sv
module pot_cmd_regfile
  import pot_cmd_pkg::*;
#(
  parameter int NPOTS     = 4,
  parameter int NREGS     = 4,
  parameter int DW        = 8,
  parameter int POS_W     = 6,
  parameter int NV_CYCLES = 2_000_000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic                stop_i,
  input  logic                byte_valid_i,
  input  logic [7:0]          byte_i,
  input  logic                step_i,
  input  logic                step_up_i,
  output logic [DW-1:0]       rd_data_o,
  output logic                busy_o,
  output logic [NPOTS*DW-1:0] wcr_o
);

  localparam int PW    = $clog2(NPOTS);
  localparam int RW    = $clog2(NREGS);
  localparam int DEPTH = NPOTS * NREGS;
  localparam int AW    = PW + RW;
  localparam logic [PW-1:0] LAST_POT = PW'(NPOTS - 1);

  // command decode
  kind_e         dec_kind;
  logic [PW-1:0] dec_pot;
  logic [RW-1:0] dec_reg;

  pot_cmd_decode #(.PW(PW), .RW(RW)) u_dec (
    .cmd_i (byte_i),
    .kind_o(dec_kind),
    .pot_o (dec_pot),
    .reg_o (dec_reg)
  );

  // transaction state
  phase_e        phase;
  kind_e         cmd_kind;
  logic [PW-1:0] cmd_pot;

  // buffered nonvolatile write
  logic          pend_valid, pend_global;
  logic [PW-1:0] pend_pot;
  logic [RW-1:0] pend_reg;
  logic [DW-1:0] pend_data;

  // read engine: walks pots, memory data returns one cycle later
  logic          seq_active, seq_to_rd;
  logic [PW-1:0] seq_pot, seq_last;
  logic [RW-1:0] seq_reg;
  logic          q_valid, q_to_rd;
  logic [PW-1:0] q_pot;

  // commit engine: writes buffered data after stop
  logic          cm_active, cm_global;
  logic [PW-1:0] cm_pot, cm_last;
  logic [RW-1:0] cm_reg;
  logic [DW-1:0] cm_data;

  logic          init_busy, nv_busy, nv_start;
  logic [DW-1:0] mem_q, mem_wdata;
  logic          mem_we;

  logic [DW-1:0] wcr    [NPOTS];
  logic          ld_en  [NPOTS];
  logic          stp_en [NPOTS];
  logic [DW-1:0] ld_val;

  logic          accept, ev_byte, wr_wcr_fire, step_fire;

  assign busy_o  = init_busy | nv_busy;
  assign accept  = !busy_o;
  assign ev_byte = accept && byte_valid_i && !stop_i && !start_i;
  assign wr_wcr_fire = ev_byte && phase == ST_WDATA && cmd_kind == K_WR_WCR;
  assign step_fire   = accept && step_i && phase == ST_STEP;
  assign nv_start    = accept && stop_i && pend_valid;

  // memory of data registers
  assign mem_we    = cm_active;
  assign mem_wdata = cm_global ? wcr[cm_pot] : cm_data;

  pot_regfile #(.DW(DW), .DEPTH(DEPTH)) u_rf (
    .clk    (clk),
    .we_i   (mem_we),
    .waddr_i({cm_pot, cm_reg}),
    .wdata_i(mem_wdata),
    .raddr_i({seq_pot, seq_reg}),
    .rdata_o(mem_q)
  );

  pot_nv_timer #(.CYCLES(NV_CYCLES)) u_tmr (
    .clk    (clk),
    .rst    (rst),
    .start_i(nv_start),
    .busy_o (nv_busy)
  );

  // wiper control
  always_comb begin
    ld_val = mem_q;
    for (int p = 0; p < NPOTS; p++) begin
      ld_en[p]  = 1'b0;
      stp_en[p] = 1'b0;
    end
    if (q_valid && !q_to_rd) begin
      ld_en[q_pot] = 1'b1;
    end else if (wr_wcr_fire) begin
      ld_en[cmd_pot] = 1'b1;
      ld_val         = byte_i;
    end
    if (step_fire) stp_en[cmd_pot] = 1'b1;
  end

  for (genvar g = 0; g < NPOTS; g++) begin : g_pot
    pot_wiper #(.DW(DW), .POS_W(POS_W)) u_wiper (
      .clk     (clk),
      .rst     (rst),
      .ld_i    (ld_en[g]),
      .ld_val_i(ld_val),
      .step_i  (stp_en[g]),
      .up_i    (step_up_i),
      .wcr_o   (wcr[g])
    );
    assign wcr_o[g*DW +: DW] = wcr[g];
  end

  // sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      phase       <= ST_IDLE;
      cmd_kind    <= K_NONE;
      cmd_pot     <= '0;
      pend_valid  <= 1'b0;
      pend_global <= 1'b0;
      pend_pot    <= '0;
      pend_reg    <= '0;
      pend_data   <= '0;
      seq_active  <= 1'b1;          // reload every wiper from register 0
      seq_to_rd   <= 1'b0;
      seq_pot     <= '0;
      seq_last    <= LAST_POT;
      seq_reg     <= '0;
      q_valid     <= 1'b0;
      q_to_rd     <= 1'b0;
      q_pot       <= '0;
      cm_active   <= 1'b0;
      cm_global   <= 1'b0;
      cm_pot      <= '0;
      cm_last     <= '0;
      cm_reg      <= '0;
      cm_data     <= '0;
      init_busy   <= 1'b1;
      rd_data_o   <= '0;
    end else begin
      q_valid   <= seq_active;
      q_to_rd   <= seq_to_rd;
      q_pot     <= seq_pot;
      init_busy <= init_busy && (seq_active || q_valid);

      if (seq_active) begin
        if (seq_pot == seq_last) seq_active <= 1'b0;
        else                     seq_pot    <= seq_pot + 1'b1;
      end
      if (q_valid && q_to_rd) rd_data_o <= mem_q;

      if (cm_active) begin
        if (cm_pot == cm_last) cm_active <= 1'b0;
        else                   cm_pot    <= cm_pot + 1'b1;
      end

      if (accept) begin
        if (stop_i) begin
          phase      <= ST_IDLE;
          pend_valid <= 1'b0;
          if (pend_valid) begin
            cm_active <= 1'b1;
            cm_global <= pend_global;
            cm_pot    <= pend_global ? '0 : pend_pot;
            cm_last   <= pend_global ? LAST_POT : pend_pot;
            cm_reg    <= pend_reg;
            cm_data   <= pend_data;
          end
        end else if (start_i) begin
          phase      <= ST_CMD;
          pend_valid <= 1'b0;
        end else if (byte_valid_i) begin
          unique case (phase)
            ST_CMD: begin
              cmd_kind <= dec_kind;
              cmd_pot  <= dec_pot;
              phase    <= ST_DONE;
              unique case (dec_kind)
                K_RD_WCR: begin
                  rd_data_o <= wcr[dec_pot];
                  phase     <= ST_RDATA;
                end
                K_RD_DR, K_D2W, K_G_D2W: begin
                  seq_active <= 1'b1;
                  seq_to_rd  <= (dec_kind == K_RD_DR);
                  seq_pot    <= (dec_kind == K_G_D2W) ? '0 : dec_pot;
                  seq_last   <= (dec_kind == K_G_D2W) ? LAST_POT : dec_pot;
                  seq_reg    <= dec_reg;
                  if (dec_kind == K_RD_DR) phase <= ST_RDATA;
                end
                K_WR_WCR, K_WR_DR: phase <= ST_WDATA;
                K_W2D, K_G_W2D: begin
                  pend_valid  <= 1'b1;
                  pend_global <= (dec_kind == K_G_W2D);
                  pend_pot    <= dec_pot;
                  pend_reg    <= dec_reg;
                  pend_data   <= wcr[dec_pot];
                end
                K_STEP:  phase <= ST_STEP;
                default: phase <= ST_DONE;
              endcase
              if (dec_kind == K_WR_DR) begin
                pend_pot <= dec_pot;
                pend_reg <= dec_reg;
              end
            end
            ST_WDATA: begin
              phase <= ST_DONE;
              if (cmd_kind == K_WR_DR) begin
                pend_valid  <= 1'b1;
                pend_global <= 1'b0;
                pend_data   <= byte_i;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/pot_cmd_regfile_chk.sv
module pot_cmd_regfile_chk #(
  parameter int NPOTS     = 4,
  parameter int DW        = 8,
  parameter int NV_CYCLES = 2_000_000
) (
  input logic                clk,
  input logic                rst,
  input logic                busy_o,
  input logic                nv_busy,
  input logic                mem_we,
  input logic                seq_active,
  input logic                cm_active,
  input logic [NPOTS*DW-1:0] wcr_o
);

  localparam int CNTW = $clog2(NV_CYCLES + 2);
  logic [CNTW-1:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (rst)          busy_cnt <= '0;
    else if (nv_busy) busy_cnt <= busy_cnt + 1'b1;
    else              busy_cnt <= '0;
  end

  // R1
  reload_busy_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> busy_o);

  // R5
  nv_window_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(nv_busy) |-> busy_cnt == CNTW'(NV_CYCLES));

  // R6
  write_in_window_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy_o);

  // R10
  engine_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({seq_active, cm_active}));

  // R13
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    nv_busy |=> $stable(wcr_o));

endmodule

bind pot_cmd_regfile pot_cmd_regfile_chk #(
  .NPOTS(NPOTS), .DW(DW), .NV_CYCLES(NV_CYCLES)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy_o    (busy_o),
  .nv_busy   (nv_busy),
  .mem_we    (mem_we),
  .seq_active(seq_active),
  .cm_active (cm_active),
  .wcr_o     (wcr_o)
);

// File: tb/test_pot_cmd_regfile.sv
`timescale 1ns/1ps
module test_pot_cmd_regfile;

  localparam int NPOTS = 4;
  localparam int DW    = 8;
  localparam int NV    = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 0, stop_i = 0, byte_valid_i = 0, step_i = 0, step_up_i = 0;
  logic [7:0] byte_i = '0;
  logic [DW-1:0] rd_data_o;
  logic busy_o;
  logic [NPOTS*DW-1:0] wcr_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pot_cmd_regfile #(.NPOTS(NPOTS), .NREGS(4), .DW(DW), .POS_W(6), .NV_CYCLES(NV)) i_pot_cmd_regfile (
    .clk(clk), .rst(rst), .start_i(start_i), .stop_i(stop_i),
    .byte_valid_i(byte_valid_i), .byte_i(byte_i), .step_i(step_i),
    .step_up_i(step_up_i), .rd_data_o(rd_data_o), .busy_o(busy_o), .wcr_o(wcr_o)
  );

  function automatic logic [7:0] wcr(input int p);
    return wcr_o[p*DW +: DW];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic gap(); repeat (8) @(negedge clk); endtask
  task automatic ev_start(); @(negedge clk) start_i = 1; @(negedge clk) start_i = 0; gap(); endtask
  task automatic ev_stop();  @(negedge clk) stop_i = 1;  @(negedge clk) stop_i = 0;  gap(); endtask
  task automatic ev_byte(input logic [7:0] b);
    @(negedge clk) begin byte_i = b; byte_valid_i = 1; end
    @(negedge clk) byte_valid_i = 0;
    gap();
  endtask
  task automatic ev_step(input logic up);
    @(negedge clk) begin step_up_i = up; step_i = 1; end
    @(negedge clk) step_i = 0;
    gap();
  endtask
  task automatic wait_idle(); repeat (NV + 10) @(negedge clk); endtask

  task automatic set_wcr(input logic [7:0] cmd, input logic [7:0] val);
    ev_start(); ev_byte(cmd); ev_byte(val); ev_stop();
  endtask

  task automatic do_reset();
    rst = 1; repeat (3) @(negedge clk);
    rst = 0; @(negedge clk);
    check("R1 busy right after reset", busy_o, 1);
    repeat (10) @(negedge clk);
    check("R1 busy clears after reload", busy_o, 0);
  endtask

  task automatic t_reset();
    do_reset();
    for (int p = 0; p < NPOTS; p++) check("R1 wiper zero at first reset", wcr(p), 0);
    check("R1 read data reset", rd_data_o, 0);
  endtask

  task automatic t_wr_wcr();
    set_wcr(8'hA4, 8'h3C);                 // pot1, reg bits ignored
    check("R3 wiper1 loaded", wcr(1), 8'h3C);
    check("R3 no busy", busy_o, 0);
    check("R2 pot0 untouched", wcr(0), 0);
    check("R2 pot2 untouched", wcr(2), 0);
    check("R2 pot3 untouched", wcr(3), 0);
  endtask

  task automatic t_rd_wcr();
    ev_start(); ev_byte(8'h94);
    check("R4 read wiper1", rd_data_o, 8'h3C);
    ev_byte(8'h00);
    check("R4 extra byte ignored rd", rd_data_o, 8'h3C);
    check("R4 extra byte ignored wcr", wcr(1), 8'h3C);
    ev_stop();
  endtask

  task automatic t_wr_dr();
    ev_start(); ev_byte(8'hC6); ev_byte(8'h5A);
    check("R5 no busy before stop", busy_o, 0);
    @(negedge clk) stop_i = 1; @(negedge clk) stop_i = 0;
    check("R5 busy after stop", busy_o, 1);
    repeat (NV - 2) @(negedge clk);
    check("R5 busy still high late in window", busy_o, 1);
    repeat (2) @(negedge clk);
    check("R5 busy low after window", busy_o, 0);
    ev_start(); ev_byte(8'hB6);
    check("R4 R5 read data reg back", rd_data_o, 8'h5A);
    ev_stop();
  endtask

  task automatic t_cancel();
    ev_start(); ev_byte(8'hC6); ev_byte(8'h11);
    ev_start(); ev_stop();
    check("R6 no busy after cancel", busy_o, 0);
    ev_start(); ev_byte(8'hB6);
    check("R6 register kept", rd_data_o, 8'h5A);
    ev_stop();
  endtask

  task automatic t_d2w();
    set_wcr(8'hA4, 8'h00);
    ev_start(); ev_byte(8'hD6);
    check("R7 wiper1 from reg2", wcr(1), 8'h5A);
    ev_stop();
    check("R7 no busy", busy_o, 0);
  endtask

  task automatic t_w2d();
    set_wcr(8'hA8, 8'h2B);
    ev_start(); ev_byte(8'hE9); ev_stop();
    check("R8 busy after store", busy_o, 1);
    wait_idle();
    ev_start(); ev_byte(8'hB9);
    check("R8 reg1 of pot2 holds wiper", rd_data_o, 8'h2B);
    ev_stop();
  endtask

  task automatic t_global();
    set_wcr(8'hA0, 8'h01);
    set_wcr(8'hA4, 8'h5A);
    set_wcr(8'hAC, 8'h33);
    ev_start(); ev_byte(8'h83); ev_stop();
    check("R10 busy after global store", busy_o, 1);
    wait_idle();
    for (int p = 0; p < NPOTS; p++) set_wcr(8'hA0 | 8'(p << 2), 8'h00);
    ev_start(); ev_byte(8'h13); ev_stop();
    check("R9 wiper0 reload", wcr(0), 8'h01);
    check("R9 wiper1 reload", wcr(1), 8'h5A);
    check("R9 wiper2 reload", wcr(2), 8'h2B);
    check("R9 wiper3 reload", wcr(3), 8'h33);
    ev_start(); ev_byte(8'hBF);
    check("R10 pot3 reg3", rd_data_o, 8'h33);
    ev_stop();
  endtask

  task automatic t_step();
    set_wcr(8'hA0, 8'hC1);
    ev_start(); ev_byte(8'h20);
    ev_step(0);
    check("R11 step down", wcr(0), 8'hC0);
    ev_step(0); ev_step(0);
    check("R11 saturate low", wcr(0), 8'hC0);
    ev_step(1); ev_step(1);
    check("R11 step up keeps top bits", wcr(0), 8'hC2);
    check("R11 other pot untouched", wcr(1), 8'h5A);
    ev_stop();
    ev_step(1);
    check("R11 no step after stop", wcr(0), 8'hC2);
    set_wcr(8'hA0, 8'h3E);
    ev_start(); ev_byte(8'h20);
    ev_step(1); ev_step(1); ev_step(1);
    check("R11 saturate high", wcr(0), 8'h3F);
    ev_stop();
  endtask

  task automatic t_unused();
    ev_start(); ev_byte(8'hF5); ev_byte(8'h77); ev_stop();
    ev_start(); ev_byte(8'h0A); ev_byte(8'h77); ev_stop();
    check("R12 wiper0", wcr(0), 8'h3F);
    check("R12 wiper1", wcr(1), 8'h5A);
    check("R12 no busy", busy_o, 0);
    ev_start(); ev_byte(8'hB6);
    check("R12 reg unchanged", rd_data_o, 8'h5A);
    ev_stop();
  endtask

  task automatic t_busy();
    ev_start(); ev_byte(8'hC8); ev_byte(8'h27); ev_stop();   // pot2 reg0
    check("R13 busy window open", busy_o, 1);
    ev_start(); ev_byte(8'hA0); ev_byte(8'h12); ev_stop();
    check("R13 write ignored while busy", wcr(0), 8'h3F);
    wait_idle();
    set_wcr(8'hA0, 8'h12);
    check("R13 write works after busy", wcr(0), 8'h12);
  endtask

  task automatic t_nv_reset();
    do_reset();
    check("R1 wiper2 from kept reg0", wcr(2), 8'h27);
    check("R1 wiper0 from reg0", wcr(0), 8'h00);
  endtask

  initial begin
    t_reset();
    t_wr_wcr();
    t_rd_wcr();
    t_wr_dr();
    t_cancel();
    t_d2w();
    t_w2d();
    t_global();
    t_step();
    t_unused();
    t_busy();
    t_nv_reset();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule